// File: doc/BRIEF.md
# Cascadable BCD Decade Counter

A four-bit synchronous up-counter that steps through the decimal digits 0 to 9 in 8421 code. It can be preset from a four-bit data input. It has two count enables that play different roles. The first is a parallel enable, which is normally shared by every stage of a chain. The second is a trickle enable, which also gates the terminal-count flag. Wiring each stage's terminal count into the trickle enable of the next stage builds a synchronous multi-decade counter with no ripple between the clocks.

The clear input is active low. A build-time parameter sets how it acts. One setting gives an asynchronous master clear, which overrides the clock. The other gives a clear that takes effect on the next rising edge. The operations rank from highest to lowest priority as follows: clear, parallel load, count, hold. The codes 10 to 15 cannot occur in normal counting. If one of them is loaded, the counter drains back into the decimal sequence within two counting clocks.

Top module: `bcd_decade_counter`

## Requirements
- R1: When counting, the value advances 0,1,...,8,9 and wraps from 9 (1001) to 0 (0000) on the rising clock edge.
- R2: With SYNC_CLEAR=0, a low on clr_n forces q to 0000 at once, without waiting for a clock edge, and keeps it there while clr_n stays low.
- R3: With SYNC_CLEAR=1, a low on clr_n clears q on the next rising edge and overrides load and count. Until that edge, q keeps its value.
- R4: With clr_n high and load_n low, data_in is copied into q on the rising edge, whatever en_par and en_trk are.
- R5: With clr_n and load_n high, q advances only when en_par and en_trk are both high. A low on either enable holds q.
- R6: term is high exactly when q is 1001 and en_trk is high. It follows en_trk in the same cycle and stays low for the codes 10 to 15.
- R7: When counting from an illegal code, the paths are 10→11→6, 12→13→4 and 14→15→2.
- R8: Two stages, where the units' term drives the tens' en_trk, count as a two-digit BCD counter and roll over from 99 to 00 in one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear, asynchronous or synchronous according to SYNC_CLEAR |
| load_n | input | 1 | Active-low parallel load |
| data_in | input | 4 | Preset value |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable, also gates term |
| q | output | 4 | Counter value |
| term | output | 1 | Terminal count: state 9 AND en_trk |

## Verification
The codes 10 to 15 never come up through counting. The only way to reach them is a load, followed by clean counting edges. The stimulus therefore loads every illegal code, both in directed sequences and through random preset values, and then counts with both enables high. The 99-to-00 carry through two chained stages is the other rare event. Directed presets of 9 and 9 reach it, and so does a long run of uninterrupted counting.

// File: rtl/bcd_cnt_pkg.sv
package bcd_cnt_pkg;
  localparam int DIGIT_W = 4;
  localparam int LAST_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic [1:0] {OP_HOLD, OP_COUNT, OP_LOAD, OP_CLEAR} op_t;

  // successor on a counting edge, including the drain paths for codes 10..15
  function automatic digit_t bcd_succ(digit_t v);
    digit_t r;
    case (v)
      4'd9:    r = 4'd0;
      4'd11:   r = 4'd6;
      4'd13:   r = 4'd4;
      4'd15:   r = 4'd2;
      default: r = v + digit_t'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bcd_op_decode.sv
module bcd_op_decode
  import bcd_cnt_pkg::*;
(
  input  logic clr_n,
  input  logic load_n,
  input  logic en_par,
  input  logic en_trk,
  output op_t  op
);
  always_comb begin
    if (!clr_n)                 op = OP_CLEAR;
    else if (!load_n)           op = OP_LOAD;
    else if (en_par && en_trk)  op = OP_COUNT;
    else                        op = OP_HOLD;
  end
endmodule

// File: rtl/bcd_next_state.sv
module bcd_next_state
  import bcd_cnt_pkg::*;
(
  input  op_t    op,
  input  digit_t cur,
  input  digit_t preset,
  output digit_t nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = preset;
      OP_COUNT: nxt = bcd_succ(cur);
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_tc_decode.sv
module bcd_tc_decode
  import bcd_cnt_pkg::*;
(
  input  digit_t cur,
  input  logic   en_trk,
  output logic   term
);
  logic at_last;
  assign at_last = (cur == digit_t'(LAST_DIGIT));
  assign term    = at_last & en_trk;
endmodule

// File: rtl/bcd_decade_counter.sv
module bcd_decade_counter
  import bcd_cnt_pkg::*;
#(
  parameter bit SYNC_CLEAR = 1'b0
) (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       load_n,
  input  logic [3:0] data_in,
  input  logic       en_par,
  input  logic       en_trk,
  output logic [3:0] q,
  output logic       term
);
  op_t    op;
  digit_t cnt_q;
  digit_t cnt_d;
  logic   cnt_en;

  bcd_op_decode u_op (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_par(en_par),
    .en_trk(en_trk),
    .op    (op)
  );

  bcd_next_state u_ns (
    .op    (op),
    .cur   (cnt_q),
    .preset(data_in),
    .nxt   (cnt_d)
  );

  assign cnt_en = (op != OP_HOLD);

  generate
    if (SYNC_CLEAR) begin : g_sync_clr
      always_ff @(posedge clk) begin
        if (cnt_en) cnt_q <= cnt_d;
      end
    end else begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end
    end
  endgenerate

  bcd_tc_decode u_tc (
    .cur   (cnt_q),
    .en_trk(en_trk),
    .term  (term)
  );

  assign q = cnt_q;
endmodule

// File: rtl/bcd_decade_counter_chk.sv
module bcd_decade_counter_chk #(
  parameter bit SYNC_CLEAR = 1'b0
) (
  input logic       clk,
  input logic       clr_n,
  input logic       load_n,
  input logic [3:0] data_in,
  input logic       en_par,
  input logic       en_trk,
  input logic [3:0] q,
  input logic       term
);
  logic run;
  assign run = clr_n && load_n && en_par && en_trk;

  // R1
  wrap_nine_chk: assert property (@(posedge clk) disable iff (!clr_n)
    run && q == 4'd9 |=> q == 4'd0);

  // R1
  step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    run && q < 4'd9 |=> q == $past(q) + 4'd1);

  // R3
  clear_edge_chk: assert property (@(posedge clk) !clr_n |=> q == 4'd0);

  generate
    if (!SYNC_CLEAR) begin : g_async
      // R2
      async_clear_chk: assert property (@(posedge clk) !clr_n |-> q == 4'd0);
    end
  endgenerate

  // R4
  load_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> q == $past(data_in));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    load_n && !(en_par && en_trk) |=> $stable(q));

  // R6
  term_state_chk: assert property (@(posedge clk) disable iff (!clr_n)
    term |-> q == 4'd9);

  // R6
  term_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !en_trk |-> !term);

  // R7
  drain11_chk: assert property (@(posedge clk) disable iff (!clr_n)
    run && q == 4'd11 |=> q == 4'd6);

  // R7
  drain13_chk: assert property (@(posedge clk) disable iff (!clr_n)
    run && q == 4'd13 |=> q == 4'd4);

  // R7
  drain15_chk: assert property (@(posedge clk) disable iff (!clr_n)
    run && q == 4'd15 |=> q == 4'd2);
endmodule

bind bcd_decade_counter bcd_decade_counter_chk #(.SYNC_CLEAR(SYNC_CLEAR)) u_chk (
  .clk    (clk),
  .clr_n  (clr_n),
  .load_n (load_n),
  .data_in(data_in),
  .en_par (en_par),
  .en_trk (en_trk),
  .q      (q),
  .term   (term)
);

// File: tb/bcd_decade_counter_tb.sv
module bcd_decade_counter_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       clr_n, load_n, en_par, en_trk;
  logic [3:0] din_lo, din_hi;
  logic [3:0] q_lo, q_hi, q_s;
  logic       term_lo, term_hi, term_s;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] e_lo, e_hi, e_s;

  bcd_decade_counter #(.SYNC_CLEAR(1'b0)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(din_lo),
    .en_par(en_par), .en_trk(en_trk), .q(q_lo), .term(term_lo));

  bcd_decade_counter #(.SYNC_CLEAR(1'b0)) u_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(din_hi),
    .en_par(en_par), .en_trk(term_lo), .q(q_hi), .term(term_hi));

  bcd_decade_counter #(.SYNC_CLEAR(1'b1)) u_sdut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .data_in(din_lo),
    .en_par(en_par), .en_trk(en_trk), .q(q_s), .term(term_s));

  function automatic logic [3:0] succ(input logic [3:0] v);
    if (v < 4'd9) return v + 4'd1;
    if (v == 4'd9) return 4'd0;
    if (v == 4'd11) return 4'd6;
    if (v == 4'd13) return 4'd4;
    if (v == 4'd15) return 4'd2;
    return v + 4'd1;
  endfunction

  task automatic chk(input string r, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic chk1(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", r, act, exp, $time);
    end
  endtask

  // drive one cycle at a falling edge, check at the next falling edge
  task automatic cyc(input logic c, input logic l, input logic [3:0] dl,
                     input logic [3:0] dh, input logic p, input logic t);
    logic [3:0] n_lo, n_hi, n_s;
    logic carry;
    string tag;
    clr_n = c; load_n = l; din_lo = dl; din_hi = dh; en_par = p; en_trk = t;
    if (!c) begin e_lo = 4'd0; e_hi = 4'd0; end
    carry = (e_lo == 4'd9) && t;
    n_lo = !c ? 4'd0 : !l ? dl : (p && t)     ? succ(e_lo) : e_lo;
    n_hi = !c ? 4'd0 : !l ? dh : (p && carry) ? succ(e_hi) : e_hi;
    n_s  = !c ? 4'd0 : !l ? dl : (p && t)     ? succ(e_s)  : e_s;
    tag = !c ? "R2" : !l ? "R4" : (p && t) ? ((e_lo > 4'd9) ? "R7" : "R1") : "R5";
    @(posedge clk);
    @(negedge clk);
    e_lo = n_lo; e_hi = n_hi; e_s = n_s;
    chk(tag, q_lo, e_lo);
    chk(!c ? "R3" : tag, q_s, e_s);
    chk("R8", q_hi, e_hi);
    chk1("R6", term_lo, (e_lo == 4'd9) && t);
    chk1("R6", term_s, (e_s == 4'd9) && t);
    chk1("R8", term_hi, (e_hi == 4'd9) && (e_lo == 4'd9) && t);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    clr_n = 1'b0; load_n = 1'b1; en_par = 1'b0; en_trk = 1'b0;
    din_lo = 4'd0; din_hi = 4'd0;
    e_lo = 4'd0; e_hi = 4'd0; e_s = 4'd0;
    @(negedge clk);
    // R2 reset state while clear is held
    chk("R2", q_lo, 4'd0);
    cyc(1'b0, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    cyc(1'b0, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    // R3 reset state of the synchronous variant
    chk("R3", q_s, 4'd0);

    // R1 plain counting through a wrap
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R1", q_lo, 4'd2);

    // R7 drain paths from every illegal code
    cyc(1'b1, 1'b0, 4'd10, 4'd0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R7", q_lo, 4'd6);
    cyc(1'b1, 1'b0, 4'd12, 4'd0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R7", q_s, 4'd4);
    cyc(1'b1, 1'b0, 4'd14, 4'd0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R7", q_lo, 4'd2);

    // R4 load ignores disabled enables; R5 hold with one enable low
    cyc(1'b1, 1'b0, 4'd5, 4'd3, 1'b0, 1'b0);
    chk("R4", q_lo, 4'd5);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b0);
    chk("R5", q_lo, 4'd5);

    // R6 term follows en_trk within the cycle
    cyc(1'b1, 1'b0, 4'd9, 4'd0, 1'b0, 1'b0);
    en_trk = 1'b1; #1;
    chk1("R6", term_lo, 1'b1);
    en_trk = 1'b0; #1;
    chk1("R6", term_lo, 1'b0);

    // R8 two-digit rollover 99 -> 00
    cyc(1'b1, 1'b0, 4'd9, 4'd9, 1'b1, 1'b1);
    cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R8", q_lo, 4'd0);
    chk("R8", q_hi, 4'd0);

    // R2 clear mid-cycle acts at once; R3 synchronous variant waits for the edge
    cyc(1'b1, 1'b0, 4'd7, 4'd4, 1'b0, 1'b0);
    clr_n = 1'b0; #1;
    chk("R2", q_lo, 4'd0);
    chk("R3", q_s, 4'd7);
    cyc(1'b0, 1'b0, 4'd3, 4'd3, 1'b1, 1'b1);
    chk("R3", q_s, 4'd0);

    // random mix
    for (int i = 0; i < 600; i++) begin
      cyc(($urandom % 25) != 0, ($urandom % 8) != 0, 4'($urandom), 4'($urandom),
          ($urandom % 4) != 0, ($urandom % 4) != 0);
    end

    // R8 long uninterrupted count from 00
    cyc(1'b1, 1'b0, 4'd0, 4'd0, 1'b1, 1'b1);
    for (int i = 0; i < 110; i++) cyc(1'b1, 1'b1, 4'd0, 4'd0, 1'b1, 1'b1);
    chk("R8", q_hi, 4'd1);
    chk("R8", q_lo, 4'd0);

    finish_run();
  end
endmodule